// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block is the receive-side write engine of an Ethernet MAC. It owns a circular list of 8-byte descriptors kept in a local word memory. Software prepares descriptors, each pointing at a buffer, and marks them as owned by hardware. It then writes a start command. The engine takes in the incoming frame as a byte stream and places the bytes into the pointed-to buffers, splitting a frame across several descriptors when it is longer than one buffer. For every descriptor it fills, it writes back the byte count and a status word, and it hands the descriptor back to software.

The engine keeps walking the ring for as long as it finds descriptors it owns. A descriptor flagged as the end of the ring sends the engine back to the programmed ring base. When the engine reaches a descriptor still owned by software, it drops its active indication and applies back-pressure to the stream until software writes the start command again. It then resumes at the same descriptor. The byte stream uses valid/ready handshaking. A byte moves only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is high only while the engine holds an open buffer. The producer must hold the data and sideband stable while `s_ready` is low. Frame-level sideband (broadcast, multicast, CRC error, alignment error, overrun) is sampled with the byte that carries `s_last`.

Top module: `rxbd_ring_engine`

## Requirements
- R1: Memory is byte-addressed with 32-bit words. The first byte of each word occupies bits 31:24. A descriptor at address A holds status in bits 31:16 and length in bits 15:0 of word A, and the buffer pointer in word A+4 (pointer bits 1:0 ignored). The host port reads combinationally and writes on the clock edge.
- R2: Only a write on `act_wr` with `act_wdata` bit 24 set starts the engine; other writes leave it idle. The first start after reset begins at `ring_base` with bits 3:0 cleared.
- R3: A fetched descriptor whose status bit 15 (empty) is clear stops the engine. `active` falls, and the next start resumes at that same descriptor, even in the middle of a frame.
- R4: `buf_size` bits 3:0 are ignored. A frame longer than one buffer fills each buffer completely. Each non-final descriptor gets length equal to the buffer size and status with bits 15 and 11 clear.
- R5: The descriptor holding the end of a frame gets status bit 11 (last). Its length is the number of bytes written to that buffer, CRC bytes included. The unused bytes of its final word are written as zero.
- R6: Status bit 13 (wrap) of a descriptor is preserved on write-back. The descriptor after a wrap descriptor is the ring base.
- R7: On the final descriptor, `s_bcast` sets bit 7, `s_mcast` bit 6, `s_align_err` bit 4, `s_crc_err` bit 2 and `s_ovr_err` bit 1.
- R8: A frame with fewer than MIN_FRAME bytes sets status bit 3 (short) on its final descriptor.
- R9: Bytes beyond `max_len` are accepted and discarded. The final descriptor then gets bits 5 (length violation) and 0 (truncated), and its length counts only stored bytes.
- R10: `s_ready` is high only while `active` is high and a buffer is open. While the engine is stopped it stays low, whatever `s_valid` does.
- R11: After reset, `active` and `s_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Ring start address (bits 3:0 ignored) |
| buf_size | input | 16 | Buffer size in bytes (bits 3:0 ignored) |
| max_len | input | 16 | Largest frame stored, in bytes |
| act_wr | input | 1 | Start-command write strobe |
| act_wdata | input | 32 | Start-command data; bit 24 starts |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Engine accepts a byte |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Byte ends the frame |
| s_bcast | input | 1 | Frame is broadcast (with last byte) |
| s_mcast | input | 1 | Frame is multicast (with last byte) |
| s_crc_err | input | 1 | CRC error (with last byte) |
| s_align_err | input | 1 | Non-octet frame (with last byte) |
| s_ovr_err | input | 1 | Receive overrun (with last byte) |
| host_we | input | 1 | Host memory write enable (engine write wins) |
| host_addr | input | 32 | Host byte address |
| host_wdata | input | 32 | Host write word |
| host_rdata | output | 32 | Host read word |
| active | output | 1 | Engine is walking the ring |

## Verification
The stimulus includes a mid-sized broadcast frame that fits one buffer and a short frame with a CRC error. These check the packing, the zero padding of a partial final word and the frame-level flags. An over-length frame spans three buffers, crosses the wrap descriptor and hits a software-owned descriptor mid-frame. It shows that the engine stalls and resumes correctly, that wrap is honoured and that truncation is marked. A multicast frame with alignment and overrun errors tests the flag placement across two buffers. A frame exactly one buffer long separates the "buffer full" case from the "frame ended" case. A start write without bit 24 confirms that such writes are ignored.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_LAST  = 11;
  localparam int ACT_BIT  = 24;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_PTR, S_FILL, S_DROP, S_WB
  } eng_state_t;

  // field order equals status bits 7..0
  typedef struct packed {
    logic bc;
    logic mc;
    logic lg;
    logic no;
    logic sh;
    logic cr;
    logic ov;
    logic tr;
  } rx_flags_t;
endpackage

// File: rtl/rxbd_mem.sv
module rxbd_mem #(
  parameter int WORDS = 1024
) (
  input  logic        clk,
  input  logic        host_we,
  input  logic [31:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic [31:0] eng_raddr,
  output logic [31:0] eng_rdata,
  input  logic        eng_we,
  input  logic [31:0] eng_waddr,
  input  logic [31:0] eng_wdata
);
  localparam int AW = $clog2(WORDS);

  logic [31:0]   mem [WORDS];
  logic [AW-1:0] h_idx, r_idx, w_idx;

  assign h_idx = host_addr[AW+1:2];
  assign r_idx = eng_raddr[AW+1:2];
  assign w_idx = eng_waddr[AW+1:2];

  assign host_rdata = mem[h_idx];
  assign eng_rdata  = mem[r_idx];

  always_ff @(posedge clk) begin
    if (eng_we)       mem[w_idx] <= eng_wdata;
    else if (host_we) mem[h_idx] <= host_wdata;
  end

  logic unused_addr_bits;
  assign unused_addr_bits = ^{host_addr[31:AW+2], host_addr[1:0], eng_raddr[31:AW+2],
                              eng_raddr[1:0], eng_waddr[31:AW+2], eng_waddr[1:0]};
endmodule

// File: rtl/rxbd_pack.sv
module rxbd_pack (
  input  logic [1:0]  pos,
  input  logic [31:0] acc,
  input  logic [7:0]  din,
  output logic [31:0] word
);
  always_comb begin
    unique case (pos)
      2'd0:    word = {din, 24'h0};
      2'd1:    word = {acc[31:24], din, 16'h0};
      2'd2:    word = {acc[31:16], din, 8'h0};
      default: word = {acc[31:8], din};
    endcase
  end

  logic unused_acc;
  assign unused_acc = ^acc[7:0];
endmodule

// File: rtl/rxbd_status.sv
module rxbd_status
  import rxbd_pkg::*;
(
  input  logic      wrap,
  input  logic      fin,
  input  rx_flags_t flags,
  output logic [15:0] status
);
  always_comb begin
    status          = 16'h0;
    status[ST_WRAP] = wrap;
    status[ST_LAST] = fin;
    status[7:0]     = fin ? flags : 8'h0;
  end
endmodule

// File: rtl/rxbd_ctrl.sv
module rxbd_ctrl
  import rxbd_pkg::*;
#(
  parameter int MIN_FRAME = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic [15:0] buf_size,
  input  logic [15:0] max_len,
  input  logic        act_wr,
  input  logic [31:0] act_wdata,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic        s_last,
  input  logic        s_bcast,
  input  logic        s_mcast,
  input  logic        s_crc_err,
  input  logic        s_align_err,
  input  logic        s_ovr_err,
  output logic [1:0]  pack_pos,
  output logic [31:0] pack_acc,
  input  logic [31:0] pack_word,
  output logic        st_wrap,
  output logic        st_fin,
  output rx_flags_t   st_flags,
  input  logic [15:0] st_word,
  output logic [31:0] eng_raddr,
  input  logic [31:0] eng_rdata,
  output logic        eng_we,
  output logic [31:0] eng_waddr,
  output logic [31:0] eng_wdata,
  output logic        desc_wb,
  output logic        active
);
  localparam logic [15:0] MIN_L = 16'(MIN_FRAME);

  eng_state_t  state;
  logic        started;
  logic [31:0] cur_desc, buf_ptr, word_acc;
  logic [15:0] chunk_cnt, frame_cnt;
  logic        wrap_q, end_q;
  rx_flags_t   flags_q;

  logic [31:0] base_al;
  logic [15:0] bsz, new_chunk, new_total;
  logic        kick, accept, buf_full, hit_max, fill_wr;

  assign base_al   = {ring_base[31:4], 4'h0};
  assign bsz       = {buf_size[15:4], 4'h0};
  assign kick      = act_wr && act_wdata[ACT_BIT];
  assign s_ready   = (state == S_FILL) || (state == S_DROP);
  assign accept    = s_valid && s_ready;
  assign new_chunk = chunk_cnt + 16'd1;
  assign new_total = frame_cnt + 16'd1;
  assign buf_full  = (new_chunk == bsz);
  assign hit_max   = (new_total == max_len);
  assign fill_wr   = accept && (state == S_FILL) &&
                     ((chunk_cnt[1:0] == 2'd3) || s_last || buf_full || hit_max);

  assign pack_pos  = chunk_cnt[1:0];
  assign pack_acc  = word_acc;
  assign st_wrap   = wrap_q;
  assign st_fin    = end_q;
  assign st_flags  = flags_q;
  assign desc_wb   = (state == S_WB);

  assign eng_raddr = (state == S_PTR) ? cur_desc + 32'd4 : cur_desc;
  assign eng_we    = fill_wr || desc_wb;
  assign eng_waddr = desc_wb ? cur_desc
                             : {buf_ptr[31:2], 2'b00} + {16'h0, chunk_cnt[15:2], 2'b00};
  assign eng_wdata = desc_wb ? {st_word, chunk_cnt} : pack_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      active    <= 1'b0;
      started   <= 1'b0;
      cur_desc  <= '0;
      buf_ptr   <= '0;
      word_acc  <= '0;
      chunk_cnt <= '0;
      frame_cnt <= '0;
      wrap_q    <= 1'b0;
      end_q     <= 1'b0;
      flags_q   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (kick) begin
          active <= 1'b1;
          state  <= S_FETCH;
          if (!started) begin
            cur_desc <= base_al;
            started  <= 1'b1;
          end
        end
        S_FETCH: begin
          if (eng_rdata[16+ST_EMPTY]) begin
            wrap_q <= eng_rdata[16+ST_WRAP];
            state  <= S_PTR;
          end else begin
            active <= 1'b0;
            state  <= S_IDLE;
          end
        end
        S_PTR: begin
          buf_ptr <= eng_rdata;
          state   <= S_FILL;
        end
        S_FILL: if (accept) begin
          word_acc  <= pack_word;
          chunk_cnt <= new_chunk;
          frame_cnt <= new_total;
          if (s_last) begin
            flags_q.bc <= s_bcast;
            flags_q.mc <= s_mcast;
            flags_q.no <= s_align_err;
            flags_q.cr <= s_crc_err;
            flags_q.ov <= s_ovr_err;
            flags_q.sh <= (new_total < MIN_L);
            end_q      <= 1'b1;
            state      <= S_WB;
          end else if (hit_max) begin
            flags_q.lg <= 1'b1;
            flags_q.tr <= 1'b1;
            state      <= S_DROP;
          end else if (buf_full) begin
            end_q <= 1'b0;
            state <= S_WB;
          end
        end
        S_DROP: if (accept && s_last) begin
          flags_q.bc <= s_bcast;
          flags_q.mc <= s_mcast;
          flags_q.no <= s_align_err;
          flags_q.cr <= s_crc_err;
          flags_q.ov <= s_ovr_err;
          end_q      <= 1'b1;
          state      <= S_WB;
        end
        S_WB: begin
          cur_desc  <= wrap_q ? base_al : cur_desc + 32'd8;
          chunk_cnt <= '0;
          if (end_q) begin
            frame_cnt <= '0;
            flags_q   <= '0;
            end_q     <= 1'b0;
          end
          state <= S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic unused_ctrl;
  assign unused_ctrl = ^{ring_base[3:0], buf_size[3:0], act_wdata[31:25], act_wdata[23:0]};
endmodule

// File: rtl/rxbd_ring_engine.sv
module rxbd_ring_engine
  import rxbd_pkg::*;
#(
  parameter int MEM_WORDS = 1024,
  parameter int MIN_FRAME = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ring_base,
  input  logic [15:0] buf_size,
  input  logic [15:0] max_len,
  input  logic        act_wr,
  input  logic [31:0] act_wdata,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [7:0]  s_data,
  input  logic        s_last,
  input  logic        s_bcast,
  input  logic        s_mcast,
  input  logic        s_crc_err,
  input  logic        s_align_err,
  input  logic        s_ovr_err,
  input  logic        host_we,
  input  logic [31:0] host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        active
);
  logic [1:0]  pack_pos;
  logic [31:0] pack_acc, pack_word;
  logic        st_wrap, st_fin;
  rx_flags_t   st_flags;
  logic [15:0] st_word;
  logic [31:0] eng_raddr, eng_rdata, eng_waddr, eng_wdata;
  logic        eng_we, desc_wb;

  rxbd_ctrl #(.MIN_FRAME(MIN_FRAME)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .buf_size(buf_size),
    .max_len(max_len), .act_wr(act_wr), .act_wdata(act_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last), .s_bcast(s_bcast),
    .s_mcast(s_mcast), .s_crc_err(s_crc_err), .s_align_err(s_align_err),
    .s_ovr_err(s_ovr_err), .pack_pos(pack_pos), .pack_acc(pack_acc),
    .pack_word(pack_word), .st_wrap(st_wrap), .st_fin(st_fin),
    .st_flags(st_flags), .st_word(st_word), .eng_raddr(eng_raddr),
    .eng_rdata(eng_rdata), .eng_we(eng_we), .eng_waddr(eng_waddr),
    .eng_wdata(eng_wdata), .desc_wb(desc_wb), .active(active)
  );

  rxbd_pack u_pack (
    .pos(pack_pos), .acc(pack_acc), .din(s_data), .word(pack_word)
  );

  rxbd_status u_status (
    .wrap(st_wrap), .fin(st_fin), .flags(st_flags), .status(st_word)
  );

  rxbd_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_raddr(eng_raddr), .eng_rdata(eng_rdata), .eng_we(eng_we),
    .eng_waddr(eng_waddr), .eng_wdata(eng_wdata)
  );
endmodule

// File: rtl/rxbd_ring_engine_chk.sv
module rxbd_ring_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        act_wr,
  input logic [31:0] act_wdata,
  input logic        s_ready,
  input logic        active,
  input logic        desc_wb,
  input logic [31:0] eng_wdata,
  input logic [15:0] buf_size
);
  // R10: stream is only accepted while the engine walks the ring
  a_r10_ready_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> active);

  // R2: the engine only becomes active after a start write with bit 24
  a_r2_rise_needs_kick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(act_wr && act_wdata[24]));

  // R4: every write-back hands the descriptor back to software
  a_r4_wb_owner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wb |-> !eng_wdata[31]);

  // R4: a written-back length never exceeds the buffer size
  a_r4_wb_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    desc_wb |-> (eng_wdata[15:0] <= {buf_size[15:4], 4'h0}));

  logic unused_chk;
  assign unused_chk = ^{act_wdata[31:25], act_wdata[23:0], eng_wdata[30:16], buf_size[3:0]};
endmodule

bind rxbd_ring_engine rxbd_ring_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .act_wr(act_wr), .act_wdata(act_wdata),
  .s_ready(s_ready), .active(active), .desc_wb(desc_wb),
  .eng_wdata(eng_wdata), .buf_size(buf_size)
);

// File: tb/rxbd_ring_engine_tb.sv
module rxbd_ring_engine_tb;
  localparam int MINF  = 8;
  localparam int BASE  = 32'h100;
  localparam int BUF   = 32'h200;
  localparam int BSZ   = 16;
  localparam int MAXL  = 40;
  localparam int NDESC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] ring_base = 32'h10B;
  logic [15:0] buf_size = 16'h13;
  logic [15:0] max_len = 16'(MAXL);
  logic act_wr = 1'b0;
  logic [31:0] act_wdata = '0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = '0;
  logic s_bcast = 1'b0, s_mcast = 1'b0, s_crc_err = 1'b0, s_align_err = 1'b0, s_ovr_err = 1'b0;
  logic host_we = 1'b0;
  logic [31:0] host_addr = '0, host_wdata = '0;
  logic [31:0] host_rdata;
  logic s_ready, active;

  always #4 clk = ~clk;

  rxbd_ring_engine #(.MEM_WORDS(1024), .MIN_FRAME(MINF)) u_dut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .buf_size(buf_size),
    .max_len(max_len), .act_wr(act_wr), .act_wdata(act_wdata),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .s_bcast(s_bcast), .s_mcast(s_mcast), .s_crc_err(s_crc_err),
    .s_align_err(s_align_err), .s_ovr_err(s_ovr_err), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .active(active)
  );

  int n_cmp = 0, n_bad = 0, m_idx = 0;
  bit done = 1'b0;
  logic [31:0] exp_mem [int];

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic host_wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = addr; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic arm(input int i);
    logic [15:0] st;
    st = (i == NDESC-1) ? 16'hA000 : 16'h8000;
    host_wr(BASE + i*8 + 4, BUF + i*64);
    host_wr(BASE + i*8, {st, 16'h0});
    exp_mem[BASE + i*8 + 4] = BUF + i*64;
    exp_mem[BASE + i*8]     = {st, 16'h0};
  endtask

  task automatic kick(input logic [31:0] v);
    @(negedge clk);
    act_wr = 1'b1; act_wdata = v;
    @(negedge clk);
    act_wr = 1'b0;
  endtask

  // called at a negedge; returns at the negedge after acceptance
  task automatic put_byte(input logic [7:0] d, input logic last, input logic [4:0] sb);
    s_valid = 1'b1; s_data = d; s_last = last;
    {s_bcast, s_mcast, s_crc_err, s_align_err, s_ovr_err} = sb;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic send(input int n, input int seed, input int from, input int upto,
                      input logic [4:0] sb);
    for (int i = from; i < upto; i++)
      put_byte(8'((seed + i) & 255), (i == n-1), sb);
  endtask

  // behavioural expectation of the ring after one frame
  task automatic model_frame(input int n, input int seed, input logic [4:0] sb);
    int stored, off, chunk, d, b;
    bit fin, trunc;
    logic [15:0] st;
    logic [31:0] w;
    trunc  = (n > MAXL);
    stored = trunc ? MAXL : n;
    off = 0;
    forever begin
      chunk = stored - off;
      if (chunk > BSZ) chunk = BSZ;
      fin = (off + chunk == stored);
      d = BASE + m_idx*8;
      b = BUF + m_idx*64;
      for (int wi = 0; wi < (chunk + 3) / 4; wi++) begin
        w = '0;
        for (int k = 0; k < 4; k++)
          if (wi*4 + k < chunk) w[31-8*k -: 8] = 8'((seed + off + wi*4 + k) & 255);
        exp_mem[b + wi*4] = w;
      end
      st = (m_idx == NDESC-1) ? 16'h2000 : 16'h0000;
      if (fin) begin
        st = st | 16'h0800;
        st[7] = sb[4]; st[6] = sb[3]; st[2] = sb[2]; st[4] = sb[1]; st[1] = sb[0];
        st[5] = trunc; st[0] = trunc;
        st[3] = (n < MINF);
      end
      exp_mem[d] = {st, 16'(chunk)};
      m_idx = (m_idx + 1) % NDESC;
      off += chunk;
      if (fin) break;
    end
  endtask

  task automatic compare_all(input string tag);
    foreach (exp_mem[a]) begin
      @(negedge clk);
      host_addr = a;
      #1;
      chk(host_rdata, exp_mem[a], tag);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk({31'b0, active}, 32'd0, "R11 active after reset");
    chk({31'b0, s_ready}, 32'd0, "R11 ready after reset");
    rst_n = 1'b1;
    for (int i = 0; i < NDESC; i++) arm(i);

    kick(32'h0000_0001);
    repeat (4) @(negedge clk);
    chk({31'b0, active}, 32'd0, "R2 start without bit 24 ignored");

    kick(32'h0100_0000);
    repeat (3) @(negedge clk);
    chk({31'b0, active}, 32'd1, "R2 start with bit 24");
    chk({31'b0, s_ready}, 32'd1, "R10 ready with open buffer");

    send(10, 8'h10, 0, 10, 5'b10000); model_frame(10, 8'h10, 5'b10000);
    send(5, 8'h40, 0, 5, 5'b00100);   model_frame(5, 8'h40, 5'b00100);
    compare_all("R1 R5 R7 R8 single-buffer frames");

    // over-length frame: crosses wrap and meets a software-owned descriptor
    send(45, 8'h80, 0, 32, 5'b00000);
    @(negedge clk);
    s_valid = 1'b1; s_data = 8'((8'h80 + 32) & 255); s_last = 1'b0;
    repeat (8) @(negedge clk);
    chk({31'b0, active}, 32'd0, "R3 stop at owned descriptor");
    chk({31'b0, s_ready}, 32'd0, "R10 back-pressure while stopped");
    arm(0);
    kick(32'h0100_0000);
    send(45, 8'h80, 32, 45, 5'b00000);
    model_frame(45, 8'h80, 5'b00000);
    repeat (6) @(negedge clk);
    chk({31'b0, active}, 32'd0, "R3 stop after ring used");
    compare_all("R4 R6 R9 split and truncated frame");

    arm(1); arm(2);
    kick(32'h0100_0000);
    send(20, 8'hC3, 0, 20, 5'b01011); model_frame(20, 8'hC3, 5'b01011);
    compare_all("R4 R7 two-buffer error frame");

    arm(3); arm(0);
    kick(32'h0100_0000);
    send(16, 8'h22, 0, 16, 5'b00000); model_frame(16, 8'h22, 5'b00000);
    repeat (4) @(negedge clk);
    chk({31'b0, s_ready}, 32'd1, "R10 ready on next owned descriptor");
    compare_all("R5 R6 exact-buffer frame on wrap descriptor");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule